// File: doc/BRIEF.md
# Indexed Address Generator with Post-Increment

This block builds the 16-bit memory address that an 8-bit processor uses for indexed loads and stores. A 3-bit register select names one register of a pair. The pair is always read with the odd register as the high byte and the even register as the low byte, so naming R5 or R4 both give R5:R4. For an offset-indexed access, an 8-bit displacement is added to the pair. The displacement is sign-extended unless the `UNSIGNED_OFS` parameter is set, in which case it is zero-extended. The sum wraps modulo 2^16 and never touches the carry. The loaded data itself is routed to R0 by the surrounding datapath.

When `AUTO_INC` is set and the odd register of the pair is named, the access also post-increments the pair by one. The address still uses the pair value from before the increment. The block returns the incremented pair value, a write-back enable and a carry pulse, which is raised only when the pair wraps from 0xFFFF to 0x0000. When no increment takes place, the carry output stays low, so the flag keeps its value. `AUTO_INC` is off by default, and then both registers of a pair give the plain access.

A small controller has two states. `ST_IDLE` holds the outputs quiet. `ST_ISSUE` presents one captured result for exactly one cycle. It has three transitions:
- accept (`ST_IDLE` to `ST_ISSUE` when start is high)
- chain (`ST_ISSUE` to `ST_ISSUE` when start is high again)
- retire (`ST_ISSUE` to `ST_IDLE` when start is low)

All operands are captured at the clock edge that samples start. Every result appears in the following cycle.

Top module: `idx_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released with no start, addr_valid, wb_en and carry_out are 0, and addr and wb_value are 0x0000.
- R2: For a plain access (kind = 0), a start sampled at a clock edge makes addr_valid 1 in the next cycle, with addr = {R[sel with bit0 forced to 1], R[sel with bit0 forced to 0]}. The register Rn occupies regs[8n+7:8n].
- R3: For an offset access (kind = 1) with UNSIGNED_OFS = 0, addr = pair + sign-extended offset, modulo 2^16.
- R4: With UNSIGNED_OFS = 1, an offset access gives addr = pair + zero-extended offset, modulo 2^16.
- R5: With AUTO_INC = 1 and reg_sel[0] = 1, wb_en is 1 in the cycle after start and wb_value = pair + 1 modulo 2^16. addr still uses the pair value from before the increment. This holds for both kinds.
- R6: When reg_sel[0] = 0, or when AUTO_INC = 0, wb_en and carry_out stay 0 for that access.
- R7: carry_out is 1 exactly when an increment takes place and the pair was 0xFFFF (so wb_value = 0x0000).
- R8: A wrap of the offset addition never raises carry_out.
- R9: Results last one cycle. Starts in consecutive cycles each produce their own result in consecutive cycles. A cycle without start is followed by addr_valid = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures operands and launches an access |
| kind | input | 1 | 0 = plain indexed, 1 = offset indexed |
| reg_sel | input | 3 | Register named by the instruction |
| regs | input | 64 | Register file contents, Rn at bits 8n+7:8n |
| offset | input | 8 | Displacement for offset accesses |
| addr | output | 16 | Effective address |
| addr_valid | output | 1 | addr holds a fresh result this cycle |
| wb_value | output | 16 | Incremented pair value to write back |
| wb_en | output | 1 | Write wb_value into the pair |
| carry_out | output | 1 | Pair wrapped on increment; set the carry flag |

## Verification
The assertions assume that start, reg_sel, kind and regs are stable around the sampling edge. They also assume the caller does not depend on addr or wb_value in cycles where addr_valid is low. The bench changes every input only on the falling edge and pulses start for whole cycles. It leaves the register file constant across each access, so the value captured at the rising edge is the one the expected results were computed from. One bench instance has AUTO_INC = 1 with signed offsets, and the other has AUTO_INC = 0 with unsigned offsets. Both see the same stimulus, so each parameter setting meets the same wrap and pair-select corners.

// File: rtl/idx_addr_pkg.sv
package idx_addr_pkg;
    typedef enum logic {
        KIND_PLAIN  = 1'b0,
        KIND_OFFSET = 1'b1
    } idx_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } idx_state_e;
endpackage

// File: rtl/idx_pair_mux.sv
module idx_pair_mux #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 8,
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int PAIR_W  = 2 * DATA_W
) (
    input  logic [NUM_REGS*DATA_W-1:0] regs,
    input  logic [SEL_W-1:0]           sel,
    output logic [PAIR_W-1:0]          pair,
    output logic                       odd
);
    logic [DATA_W-1:0] bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
        assign bank[g] = regs[g*DATA_W +: DATA_W];
    end

    logic [SEL_W-1:0] hi_idx;
    logic [SEL_W-1:0] lo_idx;

    assign hi_idx = {sel[SEL_W-1:1], 1'b1};
    assign lo_idx = {sel[SEL_W-1:1], 1'b0};
    assign pair   = {bank[hi_idx], bank[lo_idx]};
    assign odd    = sel[0];
endmodule

// File: rtl/idx_offset_add.sv
module idx_offset_add #(
    parameter int DATA_W       = 8,
    parameter bit UNSIGNED_OFS = 1'b0,
    localparam int PAIR_W      = 2 * DATA_W
) (
    input  logic [PAIR_W-1:0] pair,
    input  logic [DATA_W-1:0] offset,
    input  logic              use_ofs,
    output logic [PAIR_W-1:0] ea
);
    logic [PAIR_W-1:0] ext;

    if (UNSIGNED_OFS) begin : g_zext
        assign ext = {{DATA_W{1'b0}}, offset};
    end else begin : g_sext
        assign ext = {{DATA_W{offset[DATA_W-1]}}, offset};
    end

    assign ea = use_ofs ? pair + ext : pair;
endmodule

// File: rtl/idx_pair_inc.sv
module idx_pair_inc #(
    parameter int DATA_W  = 8,
    localparam int PAIR_W = 2 * DATA_W
) (
    input  logic [PAIR_W-1:0] pair,
    output logic [PAIR_W-1:0] next,
    output logic              wrap
);
    assign {wrap, next} = {1'b0, pair} + {{PAIR_W{1'b0}}, 1'b1};
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
    import idx_addr_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int NUM_REGS     = 8,
    parameter bit AUTO_INC     = 1'b0,
    parameter bit UNSIGNED_OFS = 1'b0,
    localparam int SEL_W       = $clog2(NUM_REGS),
    localparam int ADDR_W      = 2 * DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       kind,
    input  logic [SEL_W-1:0]           reg_sel,
    input  logic [NUM_REGS*DATA_W-1:0] regs,
    input  logic [DATA_W-1:0]          offset,
    output logic [ADDR_W-1:0]          addr,
    output logic                       addr_valid,
    output logic [ADDR_W-1:0]          wb_value,
    output logic                       wb_en,
    output logic                       carry_out
);
    idx_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pair, ea, inc_val;
    logic              odd, wrap, do_inc;
    logic [ADDR_W-1:0] addr_q, wb_q;
    logic              inc_q, cy_q;

    idx_pair_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_mux (
        .regs (regs),
        .sel  (reg_sel),
        .pair (pair),
        .odd  (odd)
    );

    idx_offset_add #(.DATA_W(DATA_W), .UNSIGNED_OFS(UNSIGNED_OFS)) u_add (
        .pair    (pair),
        .offset  (offset),
        .use_ofs (idx_kind_e'(kind) == KIND_OFFSET),
        .ea      (ea)
    );

    idx_pair_inc #(.DATA_W(DATA_W)) u_inc (
        .pair (pair),
        .next (inc_val),
        .wrap (wrap)
    );

    assign do_inc = AUTO_INC & odd;

    // next-state: accept, chain, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = start ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture at the sampling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wb_q   <= '0;
            inc_q  <= 1'b0;
            cy_q   <= 1'b0;
        end else if (start) begin
            addr_q <= ea;
            wb_q   <= do_inc ? inc_val : '0;
            inc_q  <= do_inc;
            cy_q   <= do_inc & wrap;
        end
    end

    always_comb begin
        addr     = addr_q;
        wb_value = wb_q;
        unique case (state_q)
            ST_IDLE: begin
                addr_valid = 1'b0;
                wb_en      = 1'b0;
                carry_out  = 1'b0;
            end
            ST_ISSUE: begin
                addr_valid = 1'b1;
                wb_en      = inc_q;
                carry_out  = cy_q;
            end
            default: begin
                addr_valid = 1'b0;
                wb_en      = 1'b0;
                carry_out  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/idx_addr_gen_chk.sv
module idx_addr_gen_chk #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 8,
    parameter bit AUTO_INC = 1'b0,
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int ADDR_W  = 2 * DATA_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       kind,
    input logic [SEL_W-1:0]           reg_sel,
    input logic [NUM_REGS*DATA_W-1:0] regs,
    input logic [ADDR_W-1:0]          addr,
    input logic                       addr_valid,
    input logic [ADDR_W-1:0]          wb_value,
    input logic                       wb_en,
    input logic                       carry_out
);
    logic [SEL_W-1:0]  hi_i, lo_i;
    logic [ADDR_W-1:0] pair_now;

    assign hi_i     = {reg_sel[SEL_W-1:1], 1'b1};
    assign lo_i     = {reg_sel[SEL_W-1:1], 1'b0};
    assign pair_now = {regs[hi_i*DATA_W +: DATA_W], regs[lo_i*DATA_W +: DATA_W]};

    p_valid_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> addr_valid);

    p_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !addr_valid);

    p_plain_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !kind) |=> (addr == $past(pair_now)));

    p_wb_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (addr_valid && wb_value == ADDR_W'($past(pair_now) + 1'b1)));

    p_even_no_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !reg_sel[0]) |=> (!wb_en && !carry_out));

    p_param_no_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (AUTO_INC == 1'b0) |-> !wb_en);

    p_carry_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (wb_en && wb_value == '0));
endmodule

bind idx_addr_gen idx_addr_gen_chk #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .AUTO_INC(AUTO_INC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .reg_sel(reg_sel),
    .regs(regs), .addr(addr), .addr_valid(addr_valid), .wb_value(wb_value),
    .wb_en(wb_en), .carry_out(carry_out)
);

// File: tb/idx_addr_gen_bench.sv
module idx_addr_gen_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        kind;
        logic [2:0]  sel;
        logic [7:0]  off;
        logic [15:0] m_addr;
        logic        m_wben;
        logic [15:0] m_wb;
        logic        m_cy;
        logic [15:0] a_addr;
    } vec_t;

    // R1:R0=1100 R3:R2=FFFF R5:R4=1280 R7:R6=00F0
    localparam logic [63:0] REGS = {8'h00, 8'hF0, 8'h12, 8'h80, 8'hFF, 8'hFF, 8'h11, 8'h00};
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd5, 8'h00, 16'h1280, 1'b1, 16'h1281, 1'b0, 16'h1280},
        '{1'b0, 3'd4, 8'h00, 16'h1280, 1'b0, 16'h0000, 1'b0, 16'h1280},
        '{1'b0, 3'd3, 8'h00, 16'hFFFF, 1'b1, 16'h0000, 1'b1, 16'hFFFF},
        '{1'b0, 3'd2, 8'h00, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 16'hFFFF},
        '{1'b1, 3'd1, 8'h05, 16'h1105, 1'b1, 16'h1101, 1'b0, 16'h1105},
        '{1'b1, 3'd0, 8'hFE, 16'h10FE, 1'b0, 16'h0000, 1'b0, 16'h11FE},
        '{1'b1, 3'd2, 8'h01, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 3'd7, 8'h80, 16'h0070, 1'b1, 16'h00F1, 1'b0, 16'h0170},
        '{1'b1, 3'd6, 8'h10, 16'h0100, 1'b0, 16'h0000, 1'b0, 16'h0100},
        '{1'b1, 3'd3, 8'h01, 16'h0000, 1'b1, 16'h0000, 1'b1, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        kind = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [63:0] regs = REGS;
    logic [7:0]  offset = '0;
    logic [15:0] m_addr, m_wb, a_addr, a_wb;
    logic        m_val, m_wben, m_cy, a_val, a_wben, a_cy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_addr_gen #(.AUTO_INC(1'b1), .UNSIGNED_OFS(1'b0)) u_idx_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .reg_sel(reg_sel),
        .regs(regs), .offset(offset), .addr(m_addr), .addr_valid(m_val),
        .wb_value(m_wb), .wb_en(m_wben), .carry_out(m_cy)
    );

    idx_addr_gen #(.AUTO_INC(1'b0), .UNSIGNED_OFS(1'b1)) u_idx_addr_gen_alt (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .reg_sel(reg_sel),
        .regs(regs), .offset(offset), .addr(a_addr), .addr_valid(a_val),
        .wb_value(a_wb), .wb_en(a_wben), .carry_out(a_cy)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        kind    = v.kind;
        reg_sel = v.sel;
        offset  = v.off;
        start   = 1'b1;
    endtask

    task automatic check_vec(input vec_t v);
        chk("R2 valid main", {15'd0, m_val}, 16'd1);
        chk("R2 valid alt", {15'd0, a_val}, 16'd1);
        chk(v.kind ? "R3 addr main" : "R2 addr main", m_addr, v.m_addr);
        chk(v.kind ? "R4 addr alt" : "R2 addr alt", a_addr, v.a_addr);
        chk(v.m_wben ? "R5 wb_en main" : "R6 wb_en main", {15'd0, m_wben}, {15'd0, v.m_wben});
        if (v.m_wben) chk("R5 wb_value main", m_wb, v.m_wb);
        chk((v.kind && !v.m_wben) ? "R8 carry main" : "R7 carry main", {15'd0, m_cy}, {15'd0, v.m_cy});
        chk("R6 wb_en alt", {15'd0, a_wben}, 16'd0);
        chk("R8 carry alt", {15'd0, a_cy}, 16'd0);
    endtask

    task automatic check_quiet(input string req);
        chk(req, {13'd0, m_val, m_wben, m_cy}, 16'd0);
        chk(req, {13'd0, a_val, a_wben, a_cy}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: during reset
        check_quiet("R1 in reset");
        chk("R1 addr", m_addr, 16'h0000);
        chk("R1 wb_value", m_wb, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_quiet("R1 after release");

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            start = 1'b0;
            check_vec(VECS[i]);
            @(negedge clk);
            check_quiet("R9 retire");
        end

        // R9: back-to-back starts
        @(negedge clk);
        drive(VECS[2]);
        @(negedge clk);
        check_vec(VECS[2]);
        drive(VECS[4]);
        @(negedge clk);
        check_vec(VECS[4]);
        drive(VECS[5]);
        @(negedge clk);
        start = 1'b0;
        check_vec(VECS[5]);
        @(negedge clk);
        check_quiet("R9 after chain");

        // R1: reset while a result is showing
        drive(VECS[9]);
        @(negedge clk);
        start = 1'b0;
        chk("R7 carry before reset", {15'd0, m_cy}, 16'd1);
        rst_n = 1'b0;
        #1;
        check_quiet("R1 async reset");
        chk("R1 addr after reset", m_addr, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 idle after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule